// File: doc/BRIEF.md
# Microcode Sequencer with Boot-Time Control-Store Copy

This block drives the control unit of a microcoded processor. It owns an 8-bit microinstruction address, an 8-bit instruction register fed from the data bus, and a 256-entry, 34-bit control-store RAM. The control word for the current microinstruction comes from a register, and the choice of the next address is made from that registered word.

After reset, a loader walks a boot ROM one word per clock and copies every word into the control-store RAM. The rest of the processor is held in reset until the copy is complete. Once the loader finishes, the sequencer runs from microaddress 0. On each clock it either steps to the next address or jumps. A jump goes to an address held in the microword itself, or to the opcode held in the instruction register. The second kind of jump is how an opcode fetch dispatches to its routine.

Top module: `useq_top`

## Requirements
- R1: After reset is released, `rom_addr` starts at 0 and rises by one on every clock until it reaches 255. The word on `rom_data` is stored at the address shown on `rom_addr`.
- R2: `cpu_rst_n` stays low while the copy runs. It goes high in the cycle after the word at address 255 is stored, and it then stays high until the next reset.
- R3: While `cpu_rst_n` is low, `upc` stays at 0 and `ir` keeps its value, whatever is on `data_bus`.
- R4: In the first cycle with `cpu_rst_n` high, `upc` is 0 and `ctl_word` equals the ROM word at address 0.
- R5: While running, `ctl_word` always equals the copied word at the current `upc`. Both change on the same clock edge.
- R6: If control-word bit 1 is 0, `upc` becomes `upc`+1 at the next edge and wraps from 255 to 0. In this case bit 0 and bits 9:2 have no effect.
- R7: If bit 1 is 1 and bit 0 is 0, `upc` becomes control-word bits 9:2 at the next edge.
- R8: If bit 1 is 1 and bit 0 is 1, `upc` becomes the `ir` value held before that edge. An instruction-register load in the same word does not affect the jump target.
- R9: If control-word bit 14 is 1 while running, `ir` takes `data_bus` at the next edge. Otherwise `ir` holds its value.
- R10: While `rst_n` is low at a clock edge, `upc`, `ir` and `ctl_word` clear to 0 and `cpu_rst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_addr | output | 8 | Boot ROM read address during the copy |
| rom_data | input | 34 | Boot ROM word at `rom_addr`, combinational |
| data_bus | input | 8 | Data bus that feeds the instruction register |
| cpu_rst_n | output | 1 | Active-low reset for the rest of the processor; high once the copy is done |
| upc | output | 8 | Current microinstruction address |
| ctl_word | output | 34 | Registered control word for `upc` |
| ir | output | 8 | Instruction register |

## Verification
The hardest case to reach from the ports is a microword that loads the instruction register and also jumps through it. That case shows whether the jump uses the old opcode or the new one. It can only be reached after the full 256-cycle copy, and only by routing the program there. The boot image sends an opcode-dispatch jump to address 0x20. That word loads the register and jumps to 0x30. The word at 0x30 loads a different bus value and also dispatches through the register. The driver chooses the bus value from the address it predicts for each cycle, so each of these words sees a distinct byte. Other dispatch values lead to 0xFE, so stepping wraps through 0xFF back to 0.

// File: rtl/ucs_pkg.sv
// Shared constants and the decoded sequencer-control type.
// Assumes a 34-bit control word whose sequencer fields sit at fixed bits,
// because the sequencer decodes them directly.
package ucs_pkg;
    localparam int UA_W     = 8;   // microaddress width
    localparam int CW_W     = 34;  // control-word width
    localparam int IR_W     = 8;   // instruction-register width
    localparam int JSRC_BIT = 0;   // jump source: 0 microword field, 1 IR
    localparam int JMP_BIT  = 1;   // jump enable
    localparam int TGT_LO   = 2;   // low bit of the immediate target field
    localparam int IRLD_BIT = 14;  // instruction-register load

    typedef struct packed {
        logic            jump;
        logic            from_ir;
        logic [UA_W-1:0] target;
        logic            ir_load;
    } useq_ctl_t;

    // Pick the sequencer fields out of a full control word.
    function automatic useq_ctl_t decode_ctl(input logic [CW_W-1:0] w);
        useq_ctl_t c;
        c.jump    = w[JMP_BIT];
        c.from_ir = w[JSRC_BIT];
        c.target  = w[TGT_LO +: UA_W];
        c.ir_load = w[IRLD_BIT];
        return c;
    endfunction
endpackage

// File: rtl/ucs_loader.sv
// Boot loader: copies 2**ADDR_W words from a combinational ROM into the
// control store at one word per clock, then raises done for good.
// Assumes rom_data is valid in the same cycle that rom_addr is presented.
module ucs_loader #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] cnt_q;
    logic              done_q;
    logic              last_w;

    assign last_w   = !done_q && (cnt_q == LAST);
    assign rom_addr = cnt_q;
    assign wr_en    = !done_q;
    assign wr_addr  = cnt_q;
    assign wr_data  = rom_data;
    assign rd_en    = done_q || last_w;
    assign done     = done_q;

    // Copy counter: counts up until the final word, then stays put.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!done_q && !last_w) cnt_q <= cnt_q + 1'b1;
    end

    // Done flag: set when the last word is written, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      done_q <= 1'b0;
        else if (last_w) done_q <= 1'b1;
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |=> (done_q || cnt_q == $past(cnt_q) + 1'b1));
    assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> done_q);
endmodule

// File: rtl/ucs_store.sv
// Control-store RAM: one write port used by the loader and a registered
// read port that produces the current control word.
// Assumes the loader never writes the address being read during run.
module ucs_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] word_q;

    // Write port: store the word the loader presents.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read port: register the word at the next microaddress.
    always_ff @(posedge clk) begin
        if (!rst_n)     word_q <= '0;
        else if (rd_en) word_q <= mem[rd_addr];
        else            word_q <= '0;
    end

    assign rd_word = word_q;

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> word_q == '0);
endmodule

// File: rtl/ucs_nextaddr.sv
// Next-microaddress logic and the microaddress register. Steps by one,
// jumps to an immediate target, or jumps to the instruction register.
// Assumes ctl describes the word at upc_q; run is low until boot ends.
module ucs_nextaddr
    import ucs_pkg::*;
#(
    parameter int ADDR_W = UA_W,
    parameter int OPC_W  = IR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  useq_ctl_t         ctl,
    input  logic [OPC_W-1:0]  ir_val,
    output logic [ADDR_W-1:0] upc_q,
    output logic [ADDR_W-1:0] upc_nxt
);
    // Address select: frozen at 0 before run, otherwise jump or step.
    always_comb begin
        if (!run)            upc_nxt = '0;
        else if (!ctl.jump)  upc_nxt = upc_q + 1'b1;
        else if (ctl.from_ir) upc_nxt = ADDR_W'(ir_val);
        else                 upc_nxt = ADDR_W'(ctl.target);
    end

    // Microaddress register.
    always_ff @(posedge clk) begin
        if (!rst_n) upc_q <= '0;
        else        upc_q <= upc_nxt;
    end

    assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> upc_q == '0);
    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctl.jump) |=> upc_q == $past(upc_q) + 1'b1);
    assert_imm_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl.jump && !ctl.from_ir) |=> upc_q == ADDR_W'($past(ctl.target)));
    assert_ir_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctl.jump && ctl.from_ir) |=> upc_q == ADDR_W'($past(ir_val)));
endmodule

// File: rtl/ucs_ir.sv
// Instruction register: captures the data bus when the control word asks
// for it, but only after boot has finished.
// Assumes ld comes from the registered control word.
module ucs_ir #(
    parameter int OPC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ld,
    input  logic [OPC_W-1:0] bus,
    output logic [OPC_W-1:0] ir_q
);
    // Opcode latch.
    always_ff @(posedge clk) begin
        if (!rst_n)         ir_q <= '0;
        else if (run && ld) ir_q <= bus;
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && ld) |=> $stable(ir_q));
    assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ld) |=> ir_q == $past(bus));
endmodule

// File: rtl/useq_top.sv
// Microcode sequencer top: the boot loader fills the control store, then
// the sequencer runs from microaddress 0 and holds the control word.
// Assumes a combinational boot ROM and a synchronous active-low reset.
module useq_top
    import ucs_pkg::*;
#(
    parameter int ADDR_W = UA_W,
    parameter int WORD_W = CW_W,
    parameter int OPC_W  = IR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [WORD_W-1:0] rom_data,
    input  logic [OPC_W-1:0]  data_bus,
    output logic              cpu_rst_n,
    output logic [ADDR_W-1:0] upc,
    output logic [WORD_W-1:0] ctl_word,
    output logic [OPC_W-1:0]  ir
);
    logic              wr_en, rd_en, run;
    logic [ADDR_W-1:0] wr_addr, upc_nxt, upc_q;
    logic [WORD_W-1:0] wr_data, word;
    logic [OPC_W-1:0]  ir_q;
    useq_ctl_t         ctl;

    assign ctl       = decode_ctl(word);
    assign cpu_rst_n = run;
    assign upc       = upc_q;
    assign ctl_word  = word;
    assign ir        = ir_q;

    ucs_loader #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) loader_i (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .done(run)
    );

    ucs_store #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(upc_nxt), .rd_word(word)
    );

    ucs_nextaddr #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) next_i (
        .clk(clk), .rst_n(rst_n), .run(run), .ctl(ctl), .ir_val(ir_q),
        .upc_q(upc_q), .upc_nxt(upc_nxt)
    );

    ucs_ir #(.OPC_W(OPC_W)) ir_i (
        .clk(clk), .rst_n(rst_n), .run(run), .ld(ctl.ir_load),
        .bus(data_bus), .ir_q(ir_q)
    );

    assert_start_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> upc_q == '0);
endmodule

// File: tb/useq_top_tb.sv
`timescale 1ns/1ps
module useq_top_tb_top;
    localparam int AW = 8;
    localparam int CW = 34;
    localparam int OW = 8;
    localparam int RUN_CYCLES = 1200;

    typedef struct {
        logic [AW-1:0] upc;
        logic [CW-1:0] cw;
        logic [OW-1:0] ir;
        string         rule;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] rom_addr;
    logic [CW-1:0] rom_data;
    logic [OW-1:0] data_bus = '0;
    logic          cpu_rst_n;
    logic [AW-1:0] upc;
    logic [CW-1:0] ctl_word;
    logic [OW-1:0] ir;

    logic [CW-1:0] rom_img [256];
    exp_t          sb_q[$];
    int            checks = 0;
    int            errors = 0;
    bit            finished = 0;

    always #10 clk = ~clk;

    useq_top dut_i (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
        .data_bus(data_bus), .cpu_rst_n(cpu_rst_n), .upc(upc),
        .ctl_word(ctl_word), .ir(ir)
    );

    assign rom_data = rom_img[rom_addr];

    // Boot image: payload everywhere, a few sequencer words at chosen spots.
    function automatic logic [CW-1:0] make_word(input int a);
        logic [7:0]    b = 8'(a);
        logic [CW-1:0] w;
        w = {b[2:0], b, b, b[3:0], 1'b0, 4'(~b[3:0]), ~b, 1'b0, b[0]};
        case (a)
            8'h00: w[14] = 1'b1;
            8'h01: w[1:0] = 2'b11;
            8'h20: begin w[14] = 1'b1; w[9:2] = 8'h30; w[1:0] = 2'b10; end
            8'h30: begin w[14] = 1'b1; w[1:0] = 2'b11; end
            8'h51: begin w[9:2] = 8'hFE; w[1:0] = 2'b10; end
            default: ;
        endcase
        return w;
    endfunction

    task automatic check(input string rule, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rule, act, exp);
        end
    endtask

    // Monitor: pop one expected item per cycle and compare.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.rule, " upc"}, 64'(upc), 64'(e.upc));
            check("R5 ctl_word", 64'(ctl_word), 64'(e.cw));
            check("R9 ir", 64'(ir), 64'(e.ir));
            check("R2 cpu_rst_n held", 64'(cpu_rst_n), 64'd1);
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] m_upc;
        logic [OW-1:0] m_ir;
        logic [OW-1:0] lfsr = 8'h5A;
        logic [OW-1:0] seeds [5] = '{8'h20, 8'hFE, 8'h50, 8'h03, 8'hFF};
        int round = 0;
        for (int a = 0; a < 256; a++) rom_img[a] = make_word(a);

        // R10: reset state.
        repeat (3) @(negedge clk);
        check("R10 cpu_rst_n", 64'(cpu_rst_n), 64'd0);
        check("R10 upc", 64'(upc), 64'd0);
        check("R10 ir", 64'(ir), 64'd0);
        check("R10 ctl_word", 64'(ctl_word), 64'd0);
        #1 rst_n = 1'b1;

        // R1/R2/R3: copy phase with a busy data bus.
        for (int i = 0; i < 256; i++) begin
            if (i > 0) @(negedge clk);
            check("R1 rom_addr", 64'(rom_addr), 64'(i));
            check("R2 cpu_rst_n low", 64'(cpu_rst_n), 64'd0);
            check("R3 upc frozen", 64'(upc), 64'd0);
            check("R3 ir frozen", 64'(ir), 64'd0);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            #1 data_bus = lfsr;
        end
        @(negedge clk);
        check("R2 release", 64'(cpu_rst_n), 64'd1);
        check("R4 upc", 64'(upc), 64'd0);
        check("R4 ctl_word", 64'(ctl_word), 64'(rom_img[0]));

        // Driver: choose the bus, predict the next state, push it.
        m_upc = '0;
        m_ir  = '0;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            logic [CW-1:0] w;
            logic [OW-1:0] db;
            exp_t e;
            if (c > 0) @(negedge clk);
            #1;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (m_upc == 8'h00) begin db = seeds[round % 5]; round++; end
            else if (m_upc == 8'h20) db = 8'h50;
            else if (m_upc == 8'h30) db = 8'h77;
            else db = lfsr;
            data_bus = db;
            w = rom_img[m_upc];
            if (!w[1]) begin e.upc = m_upc + 1'b1; e.rule = "R6 step"; end
            else if (!w[0]) begin e.upc = w[9:2]; e.rule = "R7 imm jump"; end
            else begin e.upc = m_ir; e.rule = "R8 ir jump"; end
            e.ir  = w[14] ? db : m_ir;
            e.cw  = rom_img[e.upc];
            m_upc = e.upc;
            m_ir  = e.ir;
            sb_q.push_back(e);
        end
        @(negedge clk);
        @(negedge clk);
        check("scoreboard drained", 64'(sb_q.size()), 64'd0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule